// File: doc/BRIEF.md
# Multi-Lane Decode Stage Flow Controller

This block sits between instruction fetch and register rename in an out-of-order core. Each cycle it can take a group of up to `LANES` instruction slots from fetch. It sends the valid, unsquashed slots on to rename, one cycle later and in the same lane positions. Real opcode decoding is not part of the block. Every slot arrives with its sequence number, PC, predicted next PC, computed branch target and a set of flags already resolved: valid, squashed, control, direct, unconditional, predicted-taken and no-source-operands.

Three downstream stages (rename, execute, commit) can each ask the block to stall. The block then parks whole fetch groups in a skid buffer, holds a stall towards fetch, and replays the parked groups oldest first before it accepts fresh groups. A squash from commit empties the buffer and silences the stage until commit lets go. When the block finds an unconditional direct branch whose predicted next PC differs from its target, it redirects fetch at decode time. It does the same for a slot that was predicted taken but is not a control instruction. Saturating event counters are exposed as outputs.

Top module: `dec_stage`

## Requirements
- R1: While reset is held, all registered outputs are zero. This covers forward valids, stall, redirect, the overflow flag and every counter.
- R2: In normal running, each slot with lane-valid high and squashed low appears on `rn_valid` in the same lane one cycle later. It carries its sequence number, and `rn_ready` is set for the slots flagged as having no source operands.
- R3: A slot that arrives with its squashed flag set is not forwarded, and it adds one to the squashed-instruction counter.
- R4: In a cycle where any of the three downstream stalls is high, nothing is forwarded on the next cycle. The incoming group, if it has any valid lane, is stored, and `fe_stall` is high from the next cycle on.
- R5: While blocked, every further group with a valid lane is stored as well, and `fe_stall` stays high.
- R6: Once all stalls are low, the stage spends one cycle switching over. It then forwards the stored groups one per cycle, oldest first. Groups that arrive meanwhile are queued behind them. `fe_stall` stays high until the cycle after the last stored group is forwarded.
- R7: A commit squash or reorder-buffer-squashing input empties the skid buffer and lowers `fe_stall` on the next cycle. Nothing is forwarded until both inputs are low, and groups offered in that time are dropped.
- R8: For a slot flagged control, direct and unconditional whose predicted next PC differs from its target, the next cycle shows the following. `fe_redirect` is high with that slot's sequence number, `fe_redirect_pc` equals the target, and `fe_redirect_taken` is 1. The slot and the earlier slots are forwarded, later slots are dropped, and the mispredict counter increments. The following cycle forwards nothing.
- R9: A slot with predicted-taken set and control clear redirects fetch in the same way. The redirect PC is its PC plus `INST_BYTES` and `fe_redirect_taken` is 0.
- R10: A group that arrives while the skid buffer already holds `SKID_DEPTH` groups, with none leaving, is not stored. It sets `skid_overflow`, which stays high until reset.
- R11: Every counter stops at its all-ones value instead of wrapping.
- R12: A cycle in idle or running state with no stall, no squash and no valid lane adds one to `cnt_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fq_lane_vld | input | LANES | Slot valid, per lane |
| fq_lane_sq | input | LANES | Slot already squashed |
| fq_is_ctrl | input | LANES | Slot is a control instruction |
| fq_is_direct | input | LANES | Control target is PC-relative |
| fq_is_uncond | input | LANES | Control is unconditional |
| fq_pred_taken | input | LANES | Predictor said taken |
| fq_no_src | input | LANES | Slot has no source operands |
| fq_seq | input | LANES*SEQ_W | Sequence numbers |
| fq_pc | input | LANES*PC_W | Slot PCs |
| fq_pred_npc | input | LANES*PC_W | Predicted next PCs |
| fq_target | input | LANES*PC_W | Computed branch targets |
| stall_rename | input | 1 | Rename stall request |
| stall_exec | input | 1 | Execute stall request |
| stall_commit | input | 1 | Commit stall request |
| cm_squash | input | 1 | Commit squash |
| cm_rob_squashing | input | 1 | Reorder buffer still squashing |
| rn_valid | output | LANES | Forwarded slot valid, per lane |
| rn_ready | output | LANES | Forwarded slot may issue at once |
| rn_seq | output | LANES*SEQ_W | Forwarded sequence numbers |
| fe_stall | output | 1 | Stall request to fetch |
| fe_redirect | output | 1 | Redirect and squash request to fetch |
| fe_redirect_taken | output | 1 | Redirect caused by a taken branch |
| fe_redirect_seq | output | SEQ_W | Sequence number of the offending slot |
| fe_redirect_pc | output | PC_W | Corrected fetch PC |
| skid_overflow | output | 1 | Sticky skid buffer overflow |
| cnt_idle | output | CNT_W | Idle cycles |
| cnt_blocked | output | CNT_W | Blocked cycles |
| cnt_unblock | output | CNT_W | Unblocking cycles |
| cnt_squash | output | CNT_W | Squashing cycles |
| cnt_decoded | output | CNT_W | Forwarded slots |
| cnt_squashed | output | CNT_W | Dropped pre-squashed slots |
| cnt_mispredict | output | CNT_W | Decode-time redirects |

## Verification
The properties assume that every stall and squash input is synchronous to `clk` and that reset is held across at least one rising edge before checking starts. They also treat lane fields as meaningful only where the lane-valid bit is set. Under those assumptions they relate the stall and squash inputs to what leaves the block on the following cycle. The stimulus changes inputs only on falling edges, keeps reset high for several cycles at the start, and drives unused lanes to zero. It breaks the fetch-side flow-control contract on purpose only once, to reach the overflow case.

// File: rtl/dec_pkg.sv
package dec_pkg;
  // Per-slot flag positions inside a packed slot word.
  localparam int F_VLD   = 0;
  localparam int F_SQ    = 1;
  localparam int F_CTRL  = 2;
  localparam int F_DIR   = 3;
  localparam int F_UNC   = 4;
  localparam int F_PTK   = 5;
  localparam int F_NOSRC = 6;
  localparam int NFLAG   = 7;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RUN   = 3'd1,
    ST_BLOCK = 3'd2,
    ST_UNBLK = 3'd3,
    ST_SQSH  = 3'd4
  } dec_state_e;
endpackage

// File: rtl/dec_sat_cnt.sv
module dec_sat_cnt #(
  parameter int W  = 16,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] inc,
  output logic [W-1:0]  val
);
  logic [W:0] sum;
  assign sum = {1'b0, val} + (W+1)'(inc);

  always_ff @(posedge clk) begin
    if (rst)         val <= '0;
    else if (sum[W]) val <= '1;
    else             val <= sum[W-1:0];
  end
endmodule

// File: rtl/dec_skid_fifo.sv
module dec_skid_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       ovf
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && (count != '0) && !clr;
  assign do_push = push && !clr && (!full || do_pop);
  assign ovf     = push && !clr && full && !do_pop;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/dec_group_scan.sv
module dec_group_scan import dec_pkg::*; #(
  parameter int LANES      = 4,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int INST_BYTES = 4
) (
  input  logic [LANES*(NFLAG+SEQ_W+3*PC_W)-1:0] grp,
  output logic [LANES-1:0]                      fwd,
  output logic [LANES-1:0]                      rdy,
  output logic                                  hit,
  output logic                                  hit_taken,
  output logic [SEQ_W-1:0]                      hit_seq,
  output logic [PC_W-1:0]                       hit_pc,
  output logic [$clog2(LANES+1)-1:0]            n_dec,
  output logic [$clog2(LANES+1)-1:0]            n_sq
);
  localparam int LW     = NFLAG + SEQ_W + 3*PC_W;
  localparam int CW     = $clog2(LANES+1);
  localparam int SEQ_LO = NFLAG;
  localparam int PC_LO  = NFLAG + SEQ_W;
  localparam int NPC_LO = PC_LO + PC_W;
  localparam int TGT_LO = NPC_LO + PC_W;

  logic [LW-1:0]   lane;
  logic [PC_W-1:0] l_pc, l_npc, l_tgt;
  logic            kill, bad_br, bad_ct;

  always_comb begin
    fwd = '0; rdy = '0; hit = 1'b0; hit_taken = 1'b0;
    hit_seq = '0; hit_pc = '0; n_dec = '0; n_sq = '0;
    kill = 1'b0; lane = '0; l_pc = '0; l_npc = '0; l_tgt = '0;
    bad_br = 1'b0; bad_ct = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      lane   = grp[i*LW +: LW];
      l_pc   = lane[PC_LO  +: PC_W];
      l_npc  = lane[NPC_LO +: PC_W];
      l_tgt  = lane[TGT_LO +: PC_W];
      bad_br = lane[F_CTRL] && lane[F_DIR] && lane[F_UNC] && (l_npc != l_tgt);
      bad_ct = lane[F_PTK] && !lane[F_CTRL];
      if (lane[F_VLD] && !kill) begin
        if (lane[F_SQ]) begin
          n_sq = n_sq + CW'(1);
        end else begin
          fwd[i] = 1'b1;
          rdy[i] = lane[F_NOSRC];
          n_dec  = n_dec + CW'(1);
          if (bad_br || bad_ct) begin
            hit       = 1'b1;
            kill      = 1'b1;
            hit_taken = bad_br;
            hit_seq   = lane[SEQ_LO +: SEQ_W];
            hit_pc    = bad_br ? l_tgt : l_pc + PC_W'(INST_BYTES);
          end
        end
      end
    end
  end
endmodule

// File: rtl/dec_stage.sv
module dec_stage import dec_pkg::*; #(
  parameter int LANES      = 4,
  parameter int SEQ_W      = 16,
  parameter int PC_W       = 32,
  parameter int SKID_DEPTH = 4,
  parameter int CNT_W      = 16,
  parameter int INST_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       fq_lane_vld,
  input  logic [LANES-1:0]       fq_lane_sq,
  input  logic [LANES-1:0]       fq_is_ctrl,
  input  logic [LANES-1:0]       fq_is_direct,
  input  logic [LANES-1:0]       fq_is_uncond,
  input  logic [LANES-1:0]       fq_pred_taken,
  input  logic [LANES-1:0]       fq_no_src,
  input  logic [LANES*SEQ_W-1:0] fq_seq,
  input  logic [LANES*PC_W-1:0]  fq_pc,
  input  logic [LANES*PC_W-1:0]  fq_pred_npc,
  input  logic [LANES*PC_W-1:0]  fq_target,
  input  logic                   stall_rename,
  input  logic                   stall_exec,
  input  logic                   stall_commit,
  input  logic                   cm_squash,
  input  logic                   cm_rob_squashing,
  output logic [LANES-1:0]       rn_valid,
  output logic [LANES-1:0]       rn_ready,
  output logic [LANES*SEQ_W-1:0] rn_seq,
  output logic                   fe_stall,
  output logic                   fe_redirect,
  output logic                   fe_redirect_taken,
  output logic [SEQ_W-1:0]       fe_redirect_seq,
  output logic [PC_W-1:0]        fe_redirect_pc,
  output logic                   skid_overflow,
  output logic [CNT_W-1:0]       cnt_idle,
  output logic [CNT_W-1:0]       cnt_blocked,
  output logic [CNT_W-1:0]       cnt_unblock,
  output logic [CNT_W-1:0]       cnt_squash,
  output logic [CNT_W-1:0]       cnt_decoded,
  output logic [CNT_W-1:0]       cnt_squashed,
  output logic [CNT_W-1:0]       cnt_mispredict
);
  localparam int LW    = NFLAG + SEQ_W + 3*PC_W;
  localparam int GW    = LANES * LW;
  localparam int SKCW  = $clog2(SKID_DEPTH+1);
  localparam int CIW   = $clog2(LANES+1);
  localparam int NCNT  = 7;

  logic [GW-1:0]          fq_grp, head_grp, src_grp;
  logic [LANES*SEQ_W-1:0] src_seq;
  logic [SKCW-1:0]        sk_count;
  logic                   sk_ovf;

  // Pack each incoming slot into one word: flags, seq, pc, predicted npc, target.
  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign fq_grp[i*LW +: LW] = {fq_target[i*PC_W +: PC_W], fq_pred_npc[i*PC_W +: PC_W],
                                 fq_pc[i*PC_W +: PC_W], fq_seq[i*SEQ_W +: SEQ_W],
                                 fq_no_src[i], fq_pred_taken[i], fq_is_uncond[i],
                                 fq_is_direct[i], fq_is_ctrl[i], fq_lane_sq[i],
                                 fq_lane_vld[i]};
    assign src_seq[i*SEQ_W +: SEQ_W] = src_grp[i*LW + NFLAG +: SEQ_W];
  end

  dec_state_e st, st_nxt;
  logic any_stall, csq, in_has, proc, push, pop, clr;

  assign any_stall = stall_rename | stall_exec | stall_commit;
  assign csq       = cm_squash | cm_rob_squashing;
  assign in_has    = |fq_lane_vld;
  assign src_grp   = (st == ST_UNBLK) ? head_grp : fq_grp;

  logic [LANES-1:0] fwd, rdy;
  logic             hit, hit_taken;
  logic [SEQ_W-1:0] hit_seq;
  logic [PC_W-1:0]  hit_pc;
  logic [CIW-1:0]   n_dec, n_sq;

  dec_group_scan #(.LANES(LANES), .SEQ_W(SEQ_W), .PC_W(PC_W), .INST_BYTES(INST_BYTES)) u_scan (
    .grp(src_grp), .fwd(fwd), .rdy(rdy), .hit(hit), .hit_taken(hit_taken),
    .hit_seq(hit_seq), .hit_pc(hit_pc), .n_dec(n_dec), .n_sq(n_sq)
  );

  dec_skid_fifo #(.W(GW), .DEPTH(SKID_DEPTH)) u_skid (
    .clk(clk), .rst(rst), .clr(clr), .push(push), .pop(pop),
    .din(fq_grp), .dout(head_grp), .count(sk_count), .ovf(sk_ovf)
  );

  always_comb begin
    st_nxt = st; proc = 1'b0; push = 1'b0; pop = 1'b0; clr = 1'b0;
    if (st != ST_SQSH && csq) begin
      st_nxt = ST_SQSH;
      clr    = 1'b1;
    end else begin
      case (st)
        ST_IDLE, ST_RUN: begin
          if (any_stall) begin
            st_nxt = ST_BLOCK;
            push   = in_has;
          end else if (in_has) begin
            proc   = 1'b1;
            st_nxt = ST_RUN;
          end else begin
            st_nxt = ST_IDLE;
          end
        end
        ST_UNBLK: begin
          if (any_stall) begin
            st_nxt = ST_BLOCK;
            push   = in_has;
          end else begin
            proc   = 1'b1;
            pop    = 1'b1;
            push   = in_has;
            st_nxt = (sk_count > SKCW'(1) || in_has) ? ST_UNBLK : ST_RUN;
          end
        end
        ST_BLOCK: begin
          push = in_has;
          if (!any_stall) st_nxt = (sk_count != '0 || in_has) ? ST_UNBLK : ST_RUN;
        end
        ST_SQSH: if (!csq) st_nxt = ST_RUN;
        default: st_nxt = ST_IDLE;
      endcase
    end
    if (proc && hit) begin
      st_nxt = ST_SQSH;
      clr    = 1'b1;
      push   = 1'b0;
      pop    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st                <= ST_IDLE;
      rn_valid          <= '0;
      rn_ready          <= '0;
      rn_seq            <= '0;
      fe_stall          <= 1'b0;
      fe_redirect       <= 1'b0;
      fe_redirect_taken <= 1'b0;
      fe_redirect_seq   <= '0;
      fe_redirect_pc    <= '0;
      skid_overflow     <= 1'b0;
    end else begin
      st                <= st_nxt;
      rn_valid          <= proc ? fwd : '0;
      rn_ready          <= proc ? rdy : '0;
      rn_seq            <= src_seq;
      fe_stall          <= (st_nxt == ST_BLOCK) || (st_nxt == ST_UNBLK);
      fe_redirect       <= proc && hit;
      fe_redirect_taken <= proc && hit && hit_taken;
      fe_redirect_seq   <= hit_seq;
      fe_redirect_pc    <= hit_pc;
      if (sk_ovf) skid_overflow <= 1'b1;
    end
  end

  // Event counters.
  logic [CIW-1:0]   c_inc [NCNT];
  logic [CNT_W-1:0] c_val [NCNT];
  logic             idle_cyc;

  assign idle_cyc = (st == ST_IDLE || st == ST_RUN) && !csq && !any_stall && !in_has;
  assign c_inc[0] = CIW'(idle_cyc);
  assign c_inc[1] = CIW'(st == ST_BLOCK);
  assign c_inc[2] = CIW'(st == ST_UNBLK);
  assign c_inc[3] = CIW'(st == ST_SQSH);
  assign c_inc[4] = proc ? n_dec : '0;
  assign c_inc[5] = proc ? n_sq : '0;
  assign c_inc[6] = CIW'(proc && hit);

  for (genvar k = 0; k < NCNT; k++) begin : g_cnt
    dec_sat_cnt #(.W(CNT_W), .IW(CIW)) u_cnt (
      .clk(clk), .rst(rst), .inc(c_inc[k]), .val(c_val[k])
    );
  end

  assign cnt_idle       = c_val[0];
  assign cnt_blocked    = c_val[1];
  assign cnt_unblock    = c_val[2];
  assign cnt_squash     = c_val[3];
  assign cnt_decoded    = c_val[4];
  assign cnt_squashed   = c_val[5];
  assign cnt_mispredict = c_val[6];
endmodule

// File: rtl/dec_stage_chk.sv
module dec_stage_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             stall_rename,
  input logic             stall_exec,
  input logic             stall_commit,
  input logic             cm_squash,
  input logic             cm_rob_squashing,
  input logic [LANES-1:0] rn_valid,
  input logic             fe_stall,
  input logic             fe_redirect,
  input logic             skid_overflow
);
  AST_STALL_NO_FWD: assert property (@(posedge clk) disable iff (rst)
    (stall_rename || stall_exec || stall_commit) |=> (rn_valid == '0)); // R4

  AST_SQUASH_SILENCES: assert property (@(posedge clk) disable iff (rst)
    (cm_squash || cm_rob_squashing) |=> (rn_valid == '0 && !fe_redirect && !fe_stall)); // R7

  AST_REDIRECT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    fe_redirect |-> !fe_stall); // R8

  AST_REDIRECT_THEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    fe_redirect |=> (rn_valid == '0 && !fe_redirect)); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    skid_overflow |=> skid_overflow); // R10
endmodule

bind dec_stage dec_stage_chk #(.LANES(LANES)) u_dec_stage_chk (
  .clk(clk), .rst(rst), .stall_rename(stall_rename), .stall_exec(stall_exec),
  .stall_commit(stall_commit), .cm_squash(cm_squash), .cm_rob_squashing(cm_rob_squashing),
  .rn_valid(rn_valid), .fe_stall(fe_stall), .fe_redirect(fe_redirect),
  .skid_overflow(skid_overflow)
);

// File: tb/dec_stage_bench.sv
`timescale 1ns/1ps
module dec_stage_bench;
  localparam int N  = 4;
  localparam int SW = 16;
  localparam int PW = 32;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [N-1:0] vld, sq, ctrl, dir, unc, ptk, nsrc;
  logic [N*SW-1:0] seq;
  logic [N*PW-1:0] pc, pnpc, tgt;
  logic st_rn, st_ex, st_cm, c_sq, c_rob;

  logic [N-1:0]    rn_valid, rn_ready;
  logic [N*SW-1:0] rn_seq;
  logic            fe_stall, fe_redirect, fe_redirect_taken, skid_overflow;
  logic [SW-1:0]   fe_redirect_seq;
  logic [PW-1:0]   fe_redirect_pc;
  logic [CW-1:0]   c_idle, c_blk, c_unb, c_sqc, c_dec, c_sqd, c_mis;

  dec_stage #(.LANES(N), .SEQ_W(SW), .PC_W(PW), .SKID_DEPTH(4), .CNT_W(CW), .INST_BYTES(4)) u_dec_stage (
    .clk(clk), .rst(rst), .fq_lane_vld(vld), .fq_lane_sq(sq), .fq_is_ctrl(ctrl),
    .fq_is_direct(dir), .fq_is_uncond(unc), .fq_pred_taken(ptk), .fq_no_src(nsrc),
    .fq_seq(seq), .fq_pc(pc), .fq_pred_npc(pnpc), .fq_target(tgt),
    .stall_rename(st_rn), .stall_exec(st_ex), .stall_commit(st_cm),
    .cm_squash(c_sq), .cm_rob_squashing(c_rob),
    .rn_valid(rn_valid), .rn_ready(rn_ready), .rn_seq(rn_seq), .fe_stall(fe_stall),
    .fe_redirect(fe_redirect), .fe_redirect_taken(fe_redirect_taken),
    .fe_redirect_seq(fe_redirect_seq), .fe_redirect_pc(fe_redirect_pc),
    .skid_overflow(skid_overflow), .cnt_idle(c_idle), .cnt_blocked(c_blk),
    .cnt_unblock(c_unb), .cnt_squash(c_sqc), .cnt_decoded(c_dec),
    .cnt_squashed(c_sqd), .cnt_mispredict(c_mis)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clr_in();
    vld = '0; sq = '0; ctrl = '0; dir = '0; unc = '0; ptk = '0; nsrc = '0;
    seq = '0; pc = '0; pnpc = '0; tgt = '0;
  endtask

  // kind: 0 plain, 1 squashed, 2 well-predicted branch, 3 mispredicted branch, 4 taken non-control
  task automatic put(input int i, input int s, input int kind);
    logic [PW-1:0] p, t;
    p = PW'(32'h1000 + s*4);
    t = PW'(32'h8000 + s*16);
    vld[i] = 1'b1;
    sq[i]  = (kind == 1);
    ctrl[i] = (kind == 2 || kind == 3);
    dir[i]  = (kind == 2 || kind == 3);
    unc[i]  = (kind == 2 || kind == 3);
    ptk[i]  = (kind == 2 || kind == 3 || kind == 4);
    seq[i*SW +: SW] = SW'(s);
    pc[i*PW +: PW]  = p;
    tgt[i*PW +: PW] = t;
    pnpc[i*PW +: PW] = (kind == 3) ? p + 4 : ((kind == 2) ? t : p + 4);
  endtask

  task automatic put_grp(input int s);
    for (int i = 0; i < N; i++) put(i, s + i, 0);
  endtask

  task automatic t_reset();
    chk("R1 rn_valid", 64'(rn_valid), 0);
    chk("R1 fe_stall", 64'(fe_stall), 0);
    chk("R1 overflow", 64'(skid_overflow), 0);
    chk("R1 cnt_decoded", 64'(c_dec), 0);
    chk("R1 cnt_idle", 64'(c_idle), 0);
  endtask

  task automatic t_idle_count();
    logic [CW-1:0] c0;
    c0 = c_idle;
    tick();
    chk("R12 idle increments", 64'(c_idle), 64'(c0 + 1'b1));
  endtask

  task automatic t_plain();
    logic [CW-1:0] d0;
    d0 = c_dec;
    clr_in(); put_grp(10); nsrc[2] = 1'b1;
    tick();
    chk("R2 rn_valid", 64'(rn_valid), 64'hF);
    chk("R2 rn_ready", 64'(rn_ready), 64'h4);
    chk("R2 lane1 seq", 64'(rn_seq[SW +: SW]), 11);
    chk("R2 decoded count", 64'(c_dec), 64'(d0 + 4));
    clr_in();
    tick();
  endtask

  task automatic t_squashed();
    logic [CW-1:0] s0;
    s0 = c_sqd;
    clr_in(); put(0, 15, 0); put(1, 16, 1);
    tick();
    chk("R3 squashed lane dropped", 64'(rn_valid), 64'h1);
    chk("R3 squashed count", 64'(c_sqd), 64'(s0 + 1'b1));
    clr_in();
    tick();
  endtask

  task automatic t_block_replay();
    clr_in(); put_grp(20); st_rn = 1'b1;
    tick();
    chk("R4 no forward", 64'(rn_valid), 0);
    chk("R4 stall up", 64'(fe_stall), 1);
    clr_in(); put_grp(30); st_rn = 1'b0; st_ex = 1'b1;
    tick();
    chk("R5 still silent", 64'(rn_valid), 0);
    chk("R5 stall held", 64'(fe_stall), 1);
    clr_in(); st_ex = 1'b0;
    tick();
    chk("R6 switch cycle silent", 64'(rn_valid), 0);
    chk("R6 stall in switch", 64'(fe_stall), 1);
    put_grp(40);
    tick();
    chk("R6 replay first", 64'(rn_seq[SW-1:0]), 20);
    chk("R6 replay valid", 64'(rn_valid), 64'hF);
    chk("R6 stall during replay", 64'(fe_stall), 1);
    clr_in();
    tick();
    chk("R6 replay second", 64'(rn_seq[SW-1:0]), 30);
    tick();
    chk("R6 queued fresh group", 64'(rn_seq[SW-1:0]), 40);
    chk("R6 stall released", 64'(fe_stall), 0);
    tick();
    chk("R6 drained", 64'(rn_valid), 0);
  endtask

  task automatic t_commit_squash();
    clr_in(); put_grp(50); st_cm = 1'b1;
    tick();
    clr_in(); c_sq = 1'b1;
    tick();
    chk("R7 stall dropped", 64'(fe_stall), 0);
    chk("R7 silent", 64'(rn_valid), 0);
    put_grp(55); c_sq = 1'b0; c_rob = 1'b1; st_cm = 1'b0;
    tick();
    chk("R7 held by rob squashing", 64'(rn_valid), 0);
    clr_in(); c_rob = 1'b0;
    tick();
    chk("R7 released silent", 64'(rn_valid), 0);
    put(0, 60, 0);
    tick();
    chk("R7 fresh group", 64'(rn_valid), 64'h1);
    chk("R7 fresh seq", 64'(rn_seq[SW-1:0]), 60);
    clr_in();
    tick();
    chk("R7 no stale replay", 64'(rn_valid), 0);
  endtask

  task automatic t_branch();
    logic [CW-1:0] m0;
    m0 = c_mis;
    clr_in(); put(0, 70, 0); put(1, 71, 3); put(2, 72, 0); put(3, 73, 2);
    tick();
    chk("R8 forwarded through branch", 64'(rn_valid), 64'h3);
    chk("R8 redirect", 64'(fe_redirect), 1);
    chk("R8 redirect seq", 64'(fe_redirect_seq), 71);
    chk("R8 redirect pc", 64'(fe_redirect_pc), 64'(32'h8000 + 71*16));
    chk("R8 taken", 64'(fe_redirect_taken), 1);
    chk("R8 mispredict count", 64'(c_mis), 64'(m0 + 1'b1));
    clr_in(); put(0, 90, 0);
    tick();
    chk("R8 group after redirect dropped", 64'(rn_valid), 0);
    chk("R8 redirect one cycle", 64'(fe_redirect), 0);
    clr_in();
    tick();
  endtask

  task automatic t_bogus_taken();
    clr_in(); put(0, 80, 4); put(1, 81, 0);
    tick();
    chk("R9 redirect", 64'(fe_redirect), 1);
    chk("R9 redirect pc", 64'(fe_redirect_pc), 64'(32'h1000 + 80*4 + 4));
    chk("R9 not taken", 64'(fe_redirect_taken), 0);
    chk("R9 forwarded", 64'(rn_valid), 64'h1);
    clr_in();
    tick();
  endtask

  task automatic t_overflow();
    st_rn = 1'b1;
    for (int g = 0; g < 5; g++) begin
      clr_in(); put(0, 100 + g, 0);
      tick();
      if (g == 3) chk("R10 full without overflow", 64'(skid_overflow), 0);
    end
    chk("R10 overflow flagged", 64'(skid_overflow), 1);
    clr_in(); st_rn = 1'b0;
    tick();
    for (int g = 0; g < 4; g++) begin
      tick();
      chk("R10 stored group", 64'(rn_seq[SW-1:0]), 64'(100 + g));
    end
    chk("R10 stall released", 64'(fe_stall), 0);
    tick();
    chk("R10 extra group lost", 64'(rn_valid), 0);
    chk("R10 flag sticky", 64'(skid_overflow), 1);
  endtask

  task automatic t_saturate();
    clr_in();
    for (int k = 0; k < 70; k++) tick();
    chk("R11 idle saturated", 64'(c_idle), 64'(2**CW - 1));
    tick();
    chk("R11 stays saturated", 64'(c_idle), 64'(2**CW - 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clr_in();
    st_rn = 1'b0; st_ex = 1'b0; st_cm = 1'b0; c_sq = 1'b0; c_rob = 1'b0;
    repeat (4) tick();
    t_reset();
    rst = 1'b0;
    tick();
    t_idle_count();
    t_plain();
    t_squashed();
    t_block_replay();
    t_commit_squash();
    t_branch();
    t_bogus_taken();
    t_overflow();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule